// File: doc/BRIEF.md
# Signed Multiply-Accumulate Unit

This block keeps a signed running sum, twice the operand width, that a processor core builds up through three commands on two signed operands. One command adds the full-width product to the sum. One subtracts it. The third returns a scaled slice of the sum and empties it. Each command takes one clock, so a stream of commands can arrive on consecutive cycles with no stall between them.

The sum is stored as an upper half and a lower half. A special-register port reads either half combinationally and writes either half. This lets software seed the sum, or save and restore it across a context switch. The slice returned by the read-and-clear command is the sum shifted right arithmetically by a parameterised amount, cut to operand width. With the default widths this is bits 59 down to 28 of the 64-bit sum.

Top module: `mac_unit`

## Requirements
- R1: After reset both halves of the sum read as zero and `res_vld_o` is low.
- R2: Command code 2'b01 adds the signed product of `opa_i` and `opb_i` to the 64-bit sum, wrapping modulo 2^64, visible on the read port after the next clock edge.
- R3: Command code 2'b10 subtracts the signed product of the operands from the sum, wrapping modulo 2^64.
- R4: Command code 2'b11 loads `res_o` with bits [59:28] of the sum as it was before the edge, raises `res_vld_o` for exactly the following cycle, and leaves both halves zero.
- R5: Commands may be issued on every cycle; each one acts on the sum left by the command of the previous cycle.
- R6: `sr_rdata_o` shows the lower half (bits [31:0]) when `sr_rsel_i` is 0 and the upper half (bits [63:32]) when it is 1, in the same cycle.
- R7: A write with `sr_we_i` high replaces the half chosen by `sr_sel_i` (0 lower, 1 upper) with `sr_wdata_i` and leaves the other half unchanged.
- R8: When a write and a command occur in the same cycle, the write takes effect and the command is discarded: the other half keeps its value, no result is produced, and `res_o` keeps its value.
- R9: Command code 2'b00 without a write leaves the sum unchanged and keeps `res_vld_o` low.
- R10: `res_o` holds its last read-and-clear value until the next read-and-clear that is not discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cmd_i | input | 2 | Command: 00 idle, 01 accumulate, 10 subtract, 11 read-and-clear |
| opa_i | input | 32 | First signed operand |
| opb_i | input | 32 | Second signed operand |
| sr_we_i | input | 1 | Special-register write strobe |
| sr_sel_i | input | 1 | Half written: 0 lower, 1 upper |
| sr_wdata_i | input | 32 | Special-register write data |
| sr_rsel_i | input | 1 | Half read: 0 lower, 1 upper |
| sr_rdata_o | output | 32 | Selected half of the sum |
| res_o | output | 32 | Last read-and-clear result |
| res_vld_o | output | 1 | High the cycle after an accepted read-and-clear |

## Verification
The read port exposes both halves in the same cycle, so a wrong sum appears on `sr_rdata_o` one clock after the faulty update. The bench therefore compares both halves after every command rather than waiting for a read-and-clear. A bad sign extension of the product or a wrong borrow across the halves shows up first in the upper half, often only when operands are negative. A wrong slice or shift shows up on `res_o` on the cycle `res_vld_o` rises. A priority error between a write and a command shows up as a changed opposite half, or a spurious `res_vld_o`, on the next cycle.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [1:0] {
    MAC_IDLE  = 2'b00,
    MAC_ADD   = 2'b01,
    MAC_SUB   = 2'b10,
    MAC_RDCLR = 2'b11
  } mac_cmd_e;

  localparam int MAC_DW_DEF    = 32;
  localparam int MAC_SHIFT_DEF = 28;

endpackage

// File: rtl/mac_mul.sv
module mac_mul #(
  parameter int DW = mac_pkg::MAC_DW_DEF,
  localparam int AW = 2 * DW
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [AW-1:0] prod_o
);

  // Full-width signed product, returned as a raw bit vector.
  function automatic logic [AW-1:0] signed_product(input logic [DW-1:0] a,
                                                   input logic [DW-1:0] b);
    logic signed [AW-1:0] wa;
    logic signed [AW-1:0] wb;
    logic signed [AW-1:0] p;
    wa = AW'($signed(a));
    wb = AW'($signed(b));
    p  = wa * wb;
    return p;
  endfunction

  assign prod_o = signed_product(a_i, b_i);

endmodule

// File: rtl/mac_next.sv
module mac_next
  import mac_pkg::*;
#(
  parameter int DW    = MAC_DW_DEF,
  parameter int SHIFT = MAC_SHIFT_DEF,
  localparam int AW = 2 * DW
) (
  input  mac_cmd_e      cmd_i,
  input  logic [AW-1:0] acc_i,
  input  logic [AW-1:0] prod_i,
  output logic [AW-1:0] acc_d_o,
  output logic          upd_o,
  output logic          res_ld_o,
  output logic [DW-1:0] res_d_o
);

  // Arithmetic right shift of the whole sum, cut to operand width.
  function automatic logic [DW-1:0] scaled_slice(input logic [AW-1:0] acc);
    logic signed [AW-1:0] s;
    s = $signed(acc) >>> SHIFT;
    return s[DW-1:0];
  endfunction

  always_comb begin
    acc_d_o  = acc_i;
    upd_o    = 1'b0;
    res_ld_o = 1'b0;
    unique case (cmd_i)
      MAC_ADD: begin
        acc_d_o = acc_i + prod_i;
        upd_o   = 1'b1;
      end
      MAC_SUB: begin
        acc_d_o = acc_i - prod_i;
        upd_o   = 1'b1;
      end
      MAC_RDCLR: begin
        acc_d_o  = '0;
        upd_o    = 1'b1;
        res_ld_o = 1'b1;
      end
      default: begin
        acc_d_o = acc_i;
      end
    endcase
  end

  assign res_d_o = scaled_slice(acc_i);

endmodule

// File: rtl/mac_acc_bank.sv
module mac_acc_bank #(
  parameter int DW = mac_pkg::MAC_DW_DEF,
  localparam int AW = 2 * DW,
  localparam int NHALF = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          upd_i,
  input  logic [AW-1:0] acc_d_i,
  input  logic          sr_we_i,
  input  logic          sr_sel_i,
  input  logic [DW-1:0] sr_wdata_i,
  output logic [AW-1:0] acc_o
);

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    logic [DW-1:0] q;
    logic          hit;
    assign hit = sr_we_i && (sr_sel_i == 1'(h));

    always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
        q <= '0;
      end else if (hit) begin
        q <= sr_wdata_i;
      end else if (!sr_we_i && upd_i) begin
        q <= acc_d_i[h*DW +: DW];
      end
    end

    assign acc_o[h*DW +: DW] = q;
  end

  // R7
  wr_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_we_i && !sr_sel_i) |=> (acc_o[DW-1:0] == $past(sr_wdata_i)) &&
                               (acc_o[AW-1:DW] == $past(acc_o[AW-1:DW])));
  // R7
  wr_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_we_i && sr_sel_i) |=> (acc_o[AW-1:DW] == $past(sr_wdata_i)) &&
                              (acc_o[DW-1:0] == $past(acc_o[DW-1:0])));

endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int DW    = MAC_DW_DEF,
  parameter int SHIFT = MAC_SHIFT_DEF,
  localparam int AW = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    cmd_i,
  input  logic [DW-1:0] opa_i,
  input  logic [DW-1:0] opb_i,
  input  logic          sr_we_i,
  input  logic          sr_sel_i,
  input  logic [DW-1:0] sr_wdata_i,
  input  logic          sr_rsel_i,
  output logic [DW-1:0] sr_rdata_o,
  output logic [DW-1:0] res_o,
  output logic          res_vld_o
);

  mac_cmd_e      cmd;
  logic [AW-1:0] prod;
  logic [AW-1:0] acc_q;
  logic [AW-1:0] acc_d;
  logic          upd;
  logic          res_ld;
  logic [DW-1:0] res_d;
  logic          res_take;
  logic [DW-1:0] res_q;
  logic          res_vld_q;

  assign cmd = mac_cmd_e'(cmd_i);

  mac_mul #(.DW(DW)) u_mul (
    .a_i   (opa_i),
    .b_i   (opb_i),
    .prod_o(prod)
  );

  mac_next #(.DW(DW), .SHIFT(SHIFT)) u_next (
    .cmd_i   (cmd),
    .acc_i   (acc_q),
    .prod_i  (prod),
    .acc_d_o (acc_d),
    .upd_o   (upd),
    .res_ld_o(res_ld),
    .res_d_o (res_d)
  );

  mac_acc_bank #(.DW(DW)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_i     (upd),
    .acc_d_i   (acc_d),
    .sr_we_i   (sr_we_i),
    .sr_sel_i  (sr_sel_i),
    .sr_wdata_i(sr_wdata_i),
    .acc_o     (acc_q)
  );

  // A register write in the same cycle cancels the result too.
  assign res_take = res_ld && !sr_we_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      res_q     <= '0;
      res_vld_q <= 1'b0;
    end else begin
      res_vld_q <= res_take;
      if (res_take) res_q <= res_d;
    end
  end

  assign sr_rdata_o = sr_rsel_i ? acc_q[AW-1:DW] : acc_q[DW-1:0];
  assign res_o      = res_q;
  assign res_vld_o  = res_vld_q;

  // R4
  rdclr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_vld_o |-> (acc_q == '0));
  // R8
  wr_cancels_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_we_i |=> (!res_vld_o && $stable(res_o)));
  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == MAC_IDLE && !sr_we_i) |=> ($stable(acc_q) && !res_vld_o));
  // R2
  add_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == MAC_ADD && !sr_we_i) |=> (acc_q == $past(acc_q) + $past(prod)));
  // R3
  sub_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == MAC_SUB && !sr_we_i) |=> (acc_q == $past(acc_q) - $past(prod)));
  // R10
  res_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_vld_o |-> $stable(res_o));

endmodule

// File: tb/mac_unit_tb.sv
`timescale 1ns/1ps
module mac_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cmd_i = 2'b00;
  logic [31:0] opa_i = '0;
  logic [31:0] opb_i = '0;
  logic        sr_we_i = 1'b0;
  logic        sr_sel_i = 1'b0;
  logic [31:0] sr_wdata_i = '0;
  logic        sr_rsel_i = 1'b0;
  logic [31:0] sr_rdata_o;
  logic [31:0] res_o;
  logic        res_vld_o;

  int checks = 0;
  int errors = 0;
  logic [63:0] m_acc = '0;
  logic [31:0] m_res = '0;

  always #2 clk = ~clk;

  mac_unit u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .cmd_i     (cmd_i),
    .opa_i     (opa_i),
    .opb_i     (opb_i),
    .sr_we_i   (sr_we_i),
    .sr_sel_i  (sr_sel_i),
    .sr_wdata_i(sr_wdata_i),
    .sr_rsel_i (sr_rsel_i),
    .sr_rdata_o(sr_rdata_o),
    .res_o     (res_o),
    .res_vld_o (res_vld_o)
  );

  function automatic logic [63:0] ref_prod(input logic [31:0] a, input logic [31:0] b);
    logic [63:0] ea;
    logic [63:0] eb;
    ea = {{32{a[31]}}, a};
    eb = {{32{b[31]}}, b};
    return ea * eb;
  endfunction

  function automatic logic [31:0] ref_slice(input logic [63:0] acc);
    return acc[59:28];
  endfunction

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_acc(input string tag);
    sr_rsel_i = 1'b0;
    #0.5;
    chk(sr_rdata_o == m_acc[31:0], tag, "low half", 64'(sr_rdata_o), 64'(m_acc[31:0]));
    sr_rsel_i = 1'b1;
    #0.5;
    chk(sr_rdata_o == m_acc[63:32], tag, "high half", 64'(sr_rdata_o), 64'(m_acc[63:32]));
  endtask

  task automatic step(input logic [1:0] c, input logic [31:0] a, input logic [31:0] b,
                      input logic we, input logic sel, input logic [31:0] wd,
                      input string tag);
    logic [63:0] p;
    logic        exp_vld;
    p = ref_prod(a, b);
    cmd_i = c; opa_i = a; opb_i = b;
    sr_we_i = we; sr_sel_i = sel; sr_wdata_i = wd;
    @(posedge clk);
    #1;
    cmd_i = 2'b00; sr_we_i = 1'b0;
    exp_vld = 1'b0;
    if (we) begin
      if (sel) m_acc[63:32] = wd;
      else     m_acc[31:0]  = wd;
    end else begin
      case (c)
        2'b01: m_acc = m_acc + p;
        2'b10: m_acc = m_acc - p;
        2'b11: begin
          m_res   = ref_slice(m_acc);
          m_acc   = '0;
          exp_vld = 1'b1;
        end
        default: ;
      endcase
    end
    chk(res_vld_o == exp_vld, tag, "res_vld", 64'(res_vld_o), 64'(exp_vld));
    chk(res_o == m_res, tag, "res", 64'(res_o), 64'(m_res));
    check_acc(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R5 watchdog expired: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = 32'd12345;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    // R1: reset state
    chk(res_vld_o == 1'b0, "R1", "res_vld after reset", 64'(res_vld_o), 64'd0);
    check_acc("R1");

    // R2: most negative squared, then a negative product
    step(2'b01, 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0, '0, "R2");
    step(2'b01, 32'hFFFF_FFFF, 32'h0000_0003, 1'b0, 1'b0, '0, "R2");
    // R3: drive sum negative
    step(2'b10, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0, 1'b0, '0, "R3");
    step(2'b10, 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0, '0, "R3");
    // R4: read-and-clear of a negative sum
    step(2'b11, '0, '0, 1'b0, 1'b0, '0, "R4");
    // R10: result held across idle and accumulate
    step(2'b00, '0, '0, 1'b0, 1'b0, '0, "R10");
    step(2'b01, 32'd5, 32'd7, 1'b0, 1'b0, '0, "R10");
    // R9: idle keeps the sum
    step(2'b00, 32'h1234_5678, 32'h9ABC_DEF0, 1'b0, 1'b0, '0, "R9");
    // R7: seed halves, then read-and-clear of a positive seeded sum
    step(2'b00, '0, '0, 1'b1, 1'b1, 32'h0ABC_DEF1, "R7");
    step(2'b00, '0, '0, 1'b1, 1'b0, 32'h2345_6789, "R7");
    step(2'b11, '0, '0, 1'b0, 1'b0, '0, "R4");
    // R6: read selection with distinct halves
    step(2'b00, '0, '0, 1'b1, 1'b1, 32'hDEAD_0001, "R6");
    step(2'b00, '0, '0, 1'b1, 1'b0, 32'h0000_BEEF, "R6");
    // R8: write collides with accumulate and with read-and-clear
    step(2'b01, 32'd100, 32'd100, 1'b1, 1'b0, 32'h1111_1111, "R8");
    step(2'b11, '0, '0, 1'b1, 1'b1, 32'h2222_2222, "R8");
    // R5: back-to-back commands
    step(2'b01, 32'hFFFF_FF00, 32'h0000_0100, 1'b0, 1'b0, '0, "R5");
    step(2'b10, 32'h0001_0000, 32'hFFFF_0000, 1'b0, 1'b0, '0, "R5");
    step(2'b11, '0, '0, 1'b0, 1'b0, '0, "R5");
    step(2'b11, '0, '0, 1'b0, 1'b0, '0, "R5");
    step(2'b01, 32'h4000_0000, 32'h0000_0004, 1'b0, 1'b0, '0, "R5");

    // Random mix (R2, R3, R4, R7, R8, R9)
    for (int i = 0; i < 400; i++) begin
      logic [1:0]  c;
      logic        we;
      string       tag;
      c  = 2'($urandom_range(0, 3));
      we = ($urandom_range(0, 7) == 0);
      if (we) tag = (c == 2'b00) ? "R7" : "R8";
      else case (c)
        2'b01:   tag = "R2";
        2'b10:   tag = "R3";
        2'b11:   tag = "R4";
        default: tag = "R9";
      endcase
      step(c, $urandom, $urandom, we, 1'($urandom_range(0, 1)), $urandom, tag);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule